// File: doc/BRIEF.md
# Dual-Phase Sync Clock Distributor

This block generates the cycle-start strobes for two switching channels that must run half a period apart. It runs on a fast system clock and has two timing sources. The first is an external sync input that may be asynchronous. Its falling edges are dealt to the channels in turn. The second is a tick from the internal oscillator. This tick arrives at twice the per-channel switching rate, and its pulses are also dealt alternately. Each channel ends up with one single-clock start strobe per switching cycle.

The external source drives the channels only while its edges come often enough. The interval between edges is measured in system clocks. If the per-channel rate implied by that interval falls below the internal rate, the block returns to the internal ticks. It takes the external source back only after a run of in-range intervals. Each channel can also request a reduced start-up rate. A channel making that request keeps only the first of every three start events routed to it.

Top module: `dual_phase_start_gen`

## Requirements
- R1: While reset is held, and directly after it, `start_pulse` is 2'b00 and `ext_active` is 0, so internal timing is selected.
- R2: With internal timing, successive `osc_tick` pulses are routed to channel 0, then channel 1, then channel 0 again, and so on. Bit 0 of `start_pulse` is channel 0. When ticks are evenly spaced, the two channels' strobes are therefore offset by half of a channel period.
- R3: Every strobe is exactly one system clock wide. At most one bit of `start_pulse` is high in any cycle.
- R4: With internal timing, falling edges of `sync_in` produce no strobe. With external timing, `osc_tick` produces no strobe.
- R5: With external timing, each falling edge of `sync_in` gives one start event. The events alternate between the channels, and after every switch to external timing the first one goes to channel 0.
- R6: An interval between two falling edges is in range when it is at most `EDGE_LIMIT` system clocks. Internal timing changes to external after two consecutive in-range intervals. The edge that completes the second interval makes no strobe. An out-of-range interval sets the count back to zero.
- R7: With external timing, the block falls back to internal timing if no falling edge arrives within `EDGE_LIMIT` clocks of the previous one. No strobe is produced in the cycle of the fallback. The first tick after the fallback goes to channel 0.
- R8: While `slow_req[c]` is 1, channel c emits a strobe only for the first of every three start events routed to it. While the bit is 0, every event gives a strobe, and the next event after a change back to 0 starts the count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| sync_in | input | 1 | External sync, asynchronous; falling edges are significant |
| osc_tick | input | 1 | One-clock pulse from the internal oscillator, at twice the channel rate |
| slow_req | input | 2 | Per-channel request for one-third rate start-up |
| start_pulse | output | 2 | One-clock cycle-start strobe per channel |
| ext_active | output | 1 | 1 while external sync sets the timing |

## Verification
The bench deals an odd number of external edges before a fallback. A design that does not reset the alternation on re-entry would then hand the first new edge to channel 1. It also sends an in-range, out-of-range, in-range pattern of intervals. A design that only counts in-range intervals, without clearing the count, would switch to external timing too early. Oscillator ticks keep running during external timing, and sync edges keep arriving during internal timing. A design that merges the two sources would produce extra strobes, and the scoreboard rejects them. The one-in-three pattern is checked against a model of the count for each channel, in both timing modes. This catches a divider that does not restart its count or that keeps the wrong event.

// File: rtl/dpsc_pkg.sv
package dpsc_pkg;
    localparam int NCH = 2;
    typedef enum logic {
        TIMING_INT = 1'b0,
        TIMING_EXT = 1'b1
    } timing_e;
endpackage

// File: rtl/sync_fall_det.sv
module sync_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } state_t;

    state_t q, d;

    always_comb begin
        d = q;
        d.sh = {q.sh[STAGES-1:0], sync_in};
    end

    // oldest sampled bit high, next one low: a falling edge
    assign fall_o = q.sh[STAGES] & ~q.sh[STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{sh: '1};
        else        q <= d;
    end
endmodule

// File: rtl/rate_monitor.sv
module rate_monitor
    import dpsc_pkg::*;
#(
    parameter int EDGE_LIMIT  = 22,
    parameter int GOOD_NEEDED = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fall_i,
    output timing_e mode_o,
    output logic    to_ext_o,
    output logic    to_int_o
);
    localparam int GW  = $clog2(EDGE_LIMIT + 1);
    localparam int GCW = $clog2(GOOD_NEEDED + 1);
    localparam logic [GW-1:0]  GAP_MAX  = GW'(EDGE_LIMIT);
    localparam logic [GCW-1:0] GOOD_TOP = GCW'(GOOD_NEEDED - 1);

    typedef struct packed {
        logic [GW-1:0]  gap;
        logic [GCW-1:0] good;
        timing_e        mode;
    } state_t;

    state_t q, d;
    logic   in_range;

    always_comb begin
        d        = q;
        to_ext_o = 1'b0;
        to_int_o = 1'b0;
        in_range = (q.gap < GAP_MAX);

        if (fall_i)             d.gap = '0;
        else if (q.gap != GAP_MAX) d.gap = q.gap + 1'b1;

        case (q.mode)
            TIMING_INT: begin
                if (fall_i) begin
                    if (!in_range) begin
                        d.good = '0;
                    end else if (q.good == GOOD_TOP) begin
                        d.good   = '0;
                        d.mode   = TIMING_EXT;
                        to_ext_o = 1'b1;
                    end else begin
                        d.good = q.good + 1'b1;
                    end
                end
            end
            default: begin
                d.good = '0;
                if (q.gap == GAP_MAX) begin
                    d.mode   = TIMING_INT;
                    to_int_o = 1'b1;
                end
            end
        endcase
    end

    assign mode_o = q.mode;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{gap: GAP_MAX, good: '0, mode: TIMING_INT};
        else        q <= d;
    end
endmodule

// File: rtl/phase_router.sv
module phase_router
    import dpsc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  timing_e        mode_i,
    input  logic           to_ext_i,
    input  logic           to_int_i,
    input  logic           fall_i,
    input  logic           osc_tick,
    output logic [NCH-1:0] event_o
);
    typedef struct packed {
        logic ext_sel;
        logic osc_sel;
    } state_t;

    state_t q, d;

    always_comb begin
        d       = q;
        event_o = '0;

        if (to_ext_i) begin
            d.ext_sel = 1'b0;
        end else if (mode_i == TIMING_EXT && fall_i && !to_int_i) begin
            event_o[q.ext_sel] = 1'b1;
            d.ext_sel          = ~q.ext_sel;
        end

        if (to_int_i) begin
            d.osc_sel = 1'b0;
        end else if (mode_i == TIMING_INT && osc_tick) begin
            event_o[q.osc_sel] = 1'b1;
            d.osc_sel          = ~q.osc_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{ext_sel: 1'b0, osc_sel: 1'b0};
        else        q <= d;
    end
endmodule

// File: rtl/start_divider.sv
module start_divider #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic slow_i,
    output logic start_o
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] CNT_TOP = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          start;
    } state_t;

    state_t q, d;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (event_i) begin
            if (slow_i) begin
                d.start = (q.cnt == '0);
                d.cnt   = (q.cnt == CNT_TOP) ? '0 : q.cnt + 1'b1;
            end else begin
                d.start = 1'b1;
                d.cnt   = '0;
            end
        end
    end

    assign start_o = q.start;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{cnt: '0, start: 1'b0};
        else        q <= d;
    end
endmodule

// File: rtl/dual_phase_start_gen.sv
module dual_phase_start_gen
    import dpsc_pkg::*;
#(
    parameter int EDGE_LIMIT  = 22,
    parameter int GOOD_NEEDED = 2,
    parameter int SYNC_STAGES = 2,
    parameter int SLOW_DIV    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sync_in,
    input  logic           osc_tick,
    input  logic [NCH-1:0] slow_req,
    output logic [NCH-1:0] start_pulse,
    output logic           ext_active
);
    logic           fall;
    timing_e        mode;
    logic           to_ext;
    logic           to_int;
    logic [NCH-1:0] chan_event;

    sync_fall_det #(.STAGES(SYNC_STAGES)) i_fall (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .fall_o(fall)
    );

    rate_monitor #(.EDGE_LIMIT(EDGE_LIMIT), .GOOD_NEEDED(GOOD_NEEDED)) i_rate (
        .clk(clk), .rst_n(rst_n), .fall_i(fall),
        .mode_o(mode), .to_ext_o(to_ext), .to_int_o(to_int)
    );

    phase_router i_route (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .to_ext_i(to_ext),
        .to_int_i(to_int), .fall_i(fall), .osc_tick(osc_tick),
        .event_o(chan_event)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        start_divider #(.DIV(SLOW_DIV)) i_div (
            .clk(clk), .rst_n(rst_n), .event_i(chan_event[c]),
            .slow_i(slow_req[c]), .start_o(start_pulse[c])
        );
    end

    assign ext_active = (mode == TIMING_EXT);
endmodule

// File: rtl/dpsc_checker.sv
module dpsc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_tick,
    input logic [1:0] start_pulse,
    input logic       ext_active
);
    assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_pulse));

    assert_one_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse != 2'b00) |=> ((start_pulse & $past(start_pulse)) == 2'b00));

    assert_int_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ext_active) && !$past(osc_tick)) |-> (start_pulse == 2'b00));

    assert_no_strobe_on_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ext_active) && !$past(osc_tick)) |-> (start_pulse == 2'b00));

    assert_quiet_on_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_active) |-> (start_pulse == 2'b00));
endmodule

bind dual_phase_start_gen dpsc_checker i_chk (.*);

// File: tb/test_dual_phase_start_gen.sv
module test_dual_phase_start_gen;
    localparam int EDGE_LIMIT = 22;
    localparam int OSC_GAP    = 20;
    localparam int IN_GAP     = 12;
    localparam int OUT_GAP    = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b1;
    logic       osc_tick = 1'b0;
    logic [1:0] slow_req = 2'b00;
    logic [1:0] start_pulse;
    logic       ext_active;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int exp_q[$];
    int bdiv[2] = '{0, 0};
    int bext_sel = 0;
    int bosc_sel = 0;
    int t_last[2] = '{0, 0};
    logic [1:0] prev_pulse = 2'b00;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    dual_phase_start_gen #(.EDGE_LIMIT(EDGE_LIMIT)) i_dual_phase_start_gen (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .osc_tick(osc_tick),
        .slow_req(slow_req), .start_pulse(start_pulse), .ext_active(ext_active)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // expected-strobe model for one routed start event (R8)
    task automatic note_event(int ch);
        if (slow_req[ch]) begin
            if (bdiv[ch] == 0) exp_q.push_back(ch);
            bdiv[ch] = (bdiv[ch] + 1) % 3;
        end else begin
            exp_q.push_back(ch);
            bdiv[ch] = 0;
        end
    endtask

    task automatic sync_fall(int gap, bit routed);
        if (routed) begin
            note_event(bext_sel);
            bext_sel ^= 1;
        end
        sync_in = 1'b0;
        repeat (gap / 2) @(negedge clk);
        sync_in = 1'b1;
        repeat (gap - gap / 2) @(negedge clk);
    endtask

    task automatic osc_pulse(int gap, bit routed);
        if (routed) begin
            note_event(bosc_sel);
            bosc_sel ^= 1;
        end
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && start_pulse != 2'b00) begin
            if ($countones(start_pulse) > 1) begin
                check(1'b0, "R3 both strobes", int'(start_pulse), 1);
            end else begin
                int ch;
                ch = start_pulse[1] ? 1 : 0;
                check((prev_pulse & start_pulse) == 2'b00, "R3 width",
                      int'(prev_pulse), 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected strobe channel", ch, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(ch == e, "R2 R5 R8 strobe channel", ch, e);
                end
                t_last[ch] = cyc;
            end
        end
        prev_pulse = start_pulse;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(start_pulse == 2'b00, "R1 strobes in reset", int'(start_pulse), 0);
        check(ext_active == 1'b0, "R1 timing in reset", int'(ext_active), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(start_pulse == 2'b00, "R1 strobes after reset", int'(start_pulse), 0);
        check(ext_active == 1'b0, "R1 timing after reset", int'(ext_active), 0);
        repeat (3) @(negedge clk);

        // internal ticks alternate, starting at channel 0 (R2)
        for (int i = 0; i < 5; i++) osc_pulse(OSC_GAP, 1'b1);
        repeat (6) @(negedge clk);
        check(t_last[0] - t_last[1] == OSC_GAP, "R2 half-period offset",
              t_last[0] - t_last[1], OSC_GAP);

        // in, out, in: count restarts, no switch, edges ignored (R6, R4)
        sync_fall(IN_GAP, 1'b0);
        sync_fall(OUT_GAP, 1'b0);
        sync_fall(IN_GAP, 1'b0);
        sync_fall(OUT_GAP, 1'b0);
        repeat (EDGE_LIMIT + 10) @(negedge clk);
        check(ext_active == 1'b0, "R6 no switch after broken run", int'(ext_active), 0);

        // acquire external timing (R6)
        for (int i = 0; i < 3; i++) sync_fall(IN_GAP, 1'b0);
        check(ext_active == 1'b1, "R6 switch after two in-range", int'(ext_active), 1);
        bext_sel = 0;

        // external edges alternate; ticks ignored meanwhile (R5, R4)
        fork
            for (int i = 0; i < 6; i++) sync_fall(IN_GAP, 1'b1);
            for (int i = 0; i < 3; i++) osc_pulse(OSC_GAP, 1'b0);
        join

        // one-in-three on channel 0 with external timing (R8)
        slow_req = 2'b01;
        for (int i = 0; i < 11; i++) sync_fall(IN_GAP, 1'b1);
        slow_req = 2'b00;

        // fallback after silence (R7)
        repeat (EDGE_LIMIT + 10) @(negedge clk);
        check(ext_active == 1'b0, "R7 fallback to internal", int'(ext_active), 0);
        bosc_sel = 0;

        // one-in-three on channel 1 with internal timing (R8, R7)
        slow_req = 2'b10;
        for (int i = 0; i < 6; i++) osc_pulse(OSC_GAP, 1'b1);
        slow_req = 2'b00;
        repeat (4) @(negedge clk);

        // re-acquire: first edge goes to channel 0 again (R5)
        for (int i = 0; i < 3; i++) sync_fall(IN_GAP, 1'b0);
        check(ext_active == 1'b1, "R6 re-acquire", int'(ext_active), 1);
        bext_sel = 0;
        sync_fall(IN_GAP, 1'b1);
        sync_fall(IN_GAP, 1'b1);
        repeat (10) @(negedge clk);

        check(exp_q.size() == 0, "R5 R8 missing strobes", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule